// File: doc/BRIEF.md
# Dual Mask Register Unit

This block holds the two bit masks that a content-addressable search engine applies to its compare and write paths. A set bit in the active mask makes the matching comparand bit a don't-care during a search, or keeps the matching destination bit unchanged during a masked write. The array those masks act on is outside this block.

The first mask has a working copy and a spare copy. A single swap command exchanges the two copies, so software can keep two mask contexts and flip between them in one clock. The second mask has no spare copy. It can be loaded, and it can be moved one bit toward the MSB or toward the LSB per command, which suits walking a mask across a key. A two-bit select chooses, per operation, which mask drives the output, or forces an all-zero mask. The output is a register, so it shows the state and selection one clock after the inputs that caused them.

Top module: `mask_pair_unit`

## Requirements
- R1: A synchronous active-high reset clears the working copy, the spare copy, the second mask and the output to all zeros, whatever the command inputs are doing.
- R2: Select codes: 2'b00 gives an all-zero output, 2'b01 gives the working copy of the first mask, 2'b10 gives the second mask, and 2'b11 gives an all-zero output.
- R3: A load of the first mask writes the load data into the working copy and leaves the spare copy unchanged.
- R4: A swap exchanges the working and spare copies of the first mask in a single clock.
- R5: When a load of the first mask and a swap arrive in the same cycle, the load is done and the swap is ignored, so the spare copy is unchanged.
- R6: A load of the second mask writes the load data into it.
- R7: A left shift moves the second mask one bit toward the MSB, a right shift moves it one bit toward the LSB; the vacated bit becomes zero and the bit shifted out is lost.
- R8: When a load of the second mask arrives together with a shift, the load takes priority and the shift is ignored.
- R9: Left and right shift requested in the same cycle (with no load) leave the second mask unchanged.
- R10: The output is registered: it reflects the select and the mask state produced at a clock edge after that edge, and does not change between edges.
- R11: With no command asserted, all mask state holds; commands for one mask never alter the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_data | input | DATA_W | Data for mask loads |
| ld_m1 | input | 1 | Load working copy of the first mask |
| swap_m1 | input | 1 | Exchange working and spare copies of the first mask |
| ld_m2 | input | 1 | Load the second mask |
| shl_m2 | input | 1 | Shift the second mask one bit toward the MSB |
| shr_m2 | input | 1 | Shift the second mask one bit toward the LSB |
| sel | input | 2 | Output mask select |
| mask_out | output | DATA_W | Registered active mask |

## Verification
The properties assume the command and select inputs are stable around the rising edge and that any combination of them may occur, including conflicting ones such as load with shift or both shift directions together. They also take the output as observable only through selection, so the shift and hold checks require the second mask to have been selected for two consecutive cycles. The stimulus changes inputs only on the falling edge and holds a select for consecutive rows when it wants a shift result to be visible, and it exercises every conflicting combination on purpose.

// File: rtl/mask_pkg.sv
package mask_pkg;
  typedef enum logic [1:0] {
    MSEL_NONE = 2'b00,
    MSEL_M1   = 2'b01,
    MSEL_M2   = 2'b10,
    MSEL_RSVD = 2'b11
  } msel_e;
endpackage

// File: rtl/mask_swap_bank.sv
module mask_swap_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         swap,
  input  logic [W-1:0] data,
  output logic [W-1:0] fg_nxt
);
  logic [W-1:0] fg_q, bg_q, bg_nxt;

  // load wins over swap; swap exchanges the two copies
  always_comb begin
    fg_nxt = fg_q;
    bg_nxt = bg_q;
    if (ld) begin
      fg_nxt = data;
    end else if (swap) begin
      fg_nxt = bg_q;
      bg_nxt = fg_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fg_q <= '0;
      bg_q <= '0;
    end else begin
      fg_q <= fg_nxt;
      bg_q <= bg_nxt;
    end
  end
endmodule

// File: rtl/mask_shift_reg.sv
module mask_shift_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         shl,
  input  logic         shr,
  input  logic [W-1:0] data,
  output logic [W-1:0] q_nxt
);
  logic [W-1:0] q;
  logic [W-1:0] up, dn;

  // per-bit neighbour selection, zero fill at both ends
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign up[i] = 1'b0;
    end else begin : g_up
      assign up[i] = q[i-1];
    end
    if (i == W-1) begin : g_msb
      assign dn[i] = 1'b0;
    end else begin : g_dn
      assign dn[i] = q[i+1];
    end
  end

  always_comb begin
    q_nxt = q;
    if (ld)              q_nxt = data;
    else if (shl && !shr) q_nxt = up;
    else if (shr && !shl) q_nxt = dn;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/mask_out_sel.sv
module mask_out_sel
  import mask_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel,
  input  logic [W-1:0] m1,
  input  logic [W-1:0] m2,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] pick;

  always_comb begin
    unique case (msel_e'(sel))
      MSEL_M1: pick = m1;
      MSEL_M2: pick = m2;
      default: pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= pick;
  end
endmodule

// File: rtl/mask_pair_unit.sv
module mask_pair_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_m1,
  input  logic              swap_m1,
  input  logic              ld_m2,
  input  logic              shl_m2,
  input  logic              shr_m2,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] mask_out
);
  logic [DATA_W-1:0] m1_nxt, m2_nxt;

  mask_swap_bank #(.W(DATA_W)) u_m1 (
    .clk(clk), .rst(rst), .ld(ld_m1), .swap(swap_m1),
    .data(ld_data), .fg_nxt(m1_nxt)
  );

  mask_shift_reg #(.W(DATA_W)) u_m2 (
    .clk(clk), .rst(rst), .ld(ld_m2), .shl(shl_m2), .shr(shr_m2),
    .data(ld_data), .q_nxt(m2_nxt)
  );

  mask_out_sel #(.W(DATA_W)) u_sel (
    .clk(clk), .rst(rst), .sel(sel), .m1(m1_nxt), .m2(m2_nxt),
    .mask_q(mask_out)
  );
endmodule

// File: rtl/mask_pair_chk.sv
module mask_pair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] ld_data,
  input logic         ld_m1,
  input logic         swap_m1,
  input logic         ld_m2,
  input logic         shl_m2,
  input logic         shr_m2,
  input logic [1:0]   sel,
  input logic [W-1:0] mask_out
);
  p_reset_zero_r1: assert property (@(posedge clk)
    $past(rst) |-> mask_out == '0);

  p_zero_sel_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == 2'b00 || $past(sel) == 2'b11) |-> mask_out == '0);

  p_load_m1_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_m1) && $past(sel) == 2'b01) |-> mask_out == $past(ld_data));

  p_load_m2_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_m2) && $past(sel) == 2'b10) |-> mask_out == $past(ld_data));

  p_shift_left_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(sel) == 2'b10 && $past(sel, 2) == 2'b10 &&
     $past(shl_m2) && !$past(shr_m2) && !$past(ld_m2))
    |-> mask_out == {$past(mask_out[W-2:0]), 1'b0});

  p_shift_right_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(sel) == 2'b10 && $past(sel, 2) == 2'b10 &&
     $past(shr_m2) && !$past(shl_m2) && !$past(ld_m2))
    |-> mask_out == {1'b0, $past(mask_out[W-1:1])});

  p_m2_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(sel) == 2'b10 && $past(sel, 2) == 2'b10 &&
     !$past(ld_m2) && ($past(shl_m2) == $past(shr_m2)))
    |-> $stable(mask_out));

  p_m1_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(sel) == 2'b01 && $past(sel, 2) == 2'b01 &&
     !$past(ld_m1) && !$past(swap_m1))
    |-> $stable(mask_out));
endmodule

bind mask_pair_unit mask_pair_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ld_data(ld_data), .ld_m1(ld_m1), .swap_m1(swap_m1),
  .ld_m2(ld_m2), .shl_m2(shl_m2), .shr_m2(shr_m2), .sel(sel), .mask_out(mask_out)
);

// File: tb/mask_pair_unit_tb_top.sv
`timescale 1ns/1ps
module mask_pair_unit_tb_top;
  localparam int W  = 16;
  localparam int VW = 5 + 2 + W + W;
  localparam int NV = 23;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ld_data = '0;
  logic         ld_m1 = 1'b0, swap_m1 = 1'b0, ld_m2 = 1'b0, shl_m2 = 1'b0, shr_m2 = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic [W-1:0] mask_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mask_pair_unit #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .ld_data(ld_data), .ld_m1(ld_m1), .swap_m1(swap_m1),
    .ld_m2(ld_m2), .shl_m2(shl_m2), .shr_m2(shr_m2), .sel(sel), .mask_out(mask_out)
  );

  // {ld_m1, ld_m2, swap_m1, shl_m2, shr_m2, sel, data, expected}
  localparam logic [VW-1:0] VECS [0:NV-1] = '{
    {5'b10000, 2'b01, 16'hA5A5, 16'hA5A5}, // R3 load working copy
    {5'b00100, 2'b01, 16'h0000, 16'h0000}, // R4 swap, spare was zero
    {5'b10000, 2'b01, 16'h1234, 16'h1234}, // R3 load, spare kept A5A5
    {5'b00100, 2'b01, 16'h0000, 16'hA5A5}, // R4 swap back
    {5'b10100, 2'b01, 16'h0F0F, 16'h0F0F}, // R5 load beats swap
    {5'b00100, 2'b01, 16'h0000, 16'h1234}, // R5 spare still 1234
    {5'b01000, 2'b10, 16'h8001, 16'h8001}, // R6 load second mask
    {5'b00010, 2'b10, 16'h0000, 16'h0002}, // R7 left, MSB lost
    {5'b00001, 2'b10, 16'h0000, 16'h0001}, // R7 right
    {5'b00001, 2'b10, 16'h0000, 16'h0000}, // R7 right, LSB lost
    {5'b01000, 2'b10, 16'hC003, 16'hC003}, // R6
    {5'b00011, 2'b10, 16'h0000, 16'hC003}, // R9 both directions
    {5'b01010, 2'b10, 16'h7FFE, 16'h7FFE}, // R8 load beats left
    {5'b01001, 2'b10, 16'h1111, 16'h1111}, // R8 load beats right
    {5'b00000, 2'b00, 16'h0000, 16'h0000}, // R2 no mask
    {5'b00000, 2'b11, 16'h0000, 16'h0000}, // R2 reserved code
    {5'b00000, 2'b01, 16'h0000, 16'h1234}, // R11 first mask held
    {5'b00000, 2'b10, 16'h0000, 16'h1111}, // R11 second mask held
    {5'b01000, 2'b01, 16'hABCD, 16'h1234}, // R11 second-mask load leaves first alone
    {5'b00000, 2'b10, 16'h0000, 16'hABCD}, // R6
    {5'b00010, 2'b10, 16'h0000, 16'h579A}, // R7
    {5'b00100, 2'b10, 16'h0000, 16'h579A}, // R11 swap leaves second mask alone
    {5'b00000, 2'b01, 16'h0000, 16'h0F0F}  // R4 swap landed
  };

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (mask_out !== exp) begin
      errors++;
      $display("FAIL %s: mask_out=%h expected=%h", req, mask_out, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [1:0] s, input logic [W-1:0] d);
    {ld_m1, ld_m2, swap_m1, shl_m2, shr_m2} = c;
    sel = s;
    ld_data = d;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", '0);  // reset state

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][VW-1 -: 5], VECS[i][2*W+1 -: 2], VECS[i][2*W-1 -: W]);
      step();
      check($sformatf("vector %0d", i), VECS[i][W-1:0]);
    end

    // R10: output does not move before the edge
    drive(5'b00000, 2'b10, '0);
    #1;
    check("R10", 16'h0F0F);
    step();
    check("R10", 16'h579A);

    // R1: reset wins over a load in the same cycle, then clears all state
    rst = 1'b1;
    drive(5'b10000, 2'b01, 16'hFFFF);
    step();
    check("R1", '0);
    rst = 1'b0;
    drive(5'b00000, 2'b01, '0);
    step();
    check("R1", '0);
    drive(5'b00100, 2'b01, '0);
    step();
    check("R1", '0);
    drive(5'b00000, 2'b10, '0);
    step();
    check("R1", '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule